// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block sits beside a receive MAC's byte assembler and decides, from the first six bytes of each frame, whether the frame is kept. It follows a strobed byte stream that carries a byte index. It compares the destination address with the station's own address and detects the all-ones broadcast address. It also recognises group (multicast) addresses and, for those, looks up one bit of a 64-entry hash table. The table index is the top six bits of the running frame CRC, as they stand once the last address byte has been taken in.

One cycle after the sixth address byte, the block makes a single decision. A rejected frame produces a one-cycle abort pulse. A separate address-miss flag records whether the address failed every check. That flag is also raised for frames kept only because promiscuous reception is on, so later logic can tell those frames apart. A control-frame path lets an external address-OK indication admit a frame when pass-all handling is enabled.

Top module: `daf_top`

## Requirements
- R1: After reset, `abort` and `addr_miss` are both 0.
- R2: Byte index k (0..5) of the frame is compared against `station_addr[47-8k:40-8k]`, so byte 0 meets bits [47:40]. A frame whose six address bytes all match is accepted: no abort, and `addr_miss` is 0 after the decision.
- R3: A unicast frame in which any single address byte differs from the station address is rejected when promiscuous mode is off. `abort` pulses and `addr_miss` becomes 1.
- R4: A frame is broadcast only if all six address bytes equal 0xFF. With `bcast_block`=0 such a frame is accepted. A single non-0xFF byte at any of the six positions removes the broadcast status, and the frame is then judged by the other checks.
- R5: With `bcast_block`=1, a broadcast frame is rejected. Broadcast frames do not take the multicast hash path.
- R6: A non-broadcast frame whose byte 0 has bit 0 set is multicast. It is accepted only if the table bit selected by the captured index is 1. Index i in 0..31 selects `hash_lo[i]`, and index i in 32..63 selects `hash_hi[i-32]`.
- R7: The hash index is the value on `crc_hi` in the cycle the byte with index 5 is strobed. Later changes of `crc_hi` do not alter the decision. The index returns to 0 while `rx_idle` is high.
- R8: With `promisc`=1, a frame that fails every address check is not aborted, but `addr_miss` becomes 1.
- R9: A frame that fails the address checks is admitted (no abort, `addr_miss`=0) when `pass_ctrl` and `ctrl_addr_ok` are both 1. Either one alone does not admit it.
- R10: The decision is taken in the cycle after the byte-5 strobe. `abort` rises one clock after that and is high for exactly one cycle. No abort is issued if the receiver has left the data phase or is idle at the decision.
- R11: `addr_miss` holds its value after the decision until the byte-0 strobe of the next frame, and is 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_idle | input | 1 | Receiver is between frames |
| rx_data_phase | input | 1 | Receiver is in the frame data phase |
| byte_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete byte |
| byte_idx | input | 8 | Position of the strobed byte in the frame, 0 = first address byte |
| rx_byte | input | 8 | Received byte |
| frame_end | input | 1 | End-of-frame pulse |
| crc_hi | input | 6 | Top six bits of the running CRC |
| station_addr | input | 48 | Own station address, first transmitted byte in [47:40] |
| bcast_block | input | 1 | Reject broadcast frames |
| promisc | input | 1 | Keep frames that fail all address checks |
| hash_lo | input | 32 | Hash table entries 0..31 |
| hash_hi | input | 32 | Hash table entries 32..63 |
| pass_ctrl | input | 1 | Pass-all handling of control frames enabled |
| ctrl_addr_ok | input | 1 | External control-frame address match |
| abort | output | 1 | One-cycle pulse: frame rejected |
| addr_miss | output | 1 | Frame address failed every check |

## Verification
Every cycle, the assertions check several timing and status properties. The abort pulse is one cycle wide and comes two clocks after the last address byte. It never fires with promiscuous mode on. The multicast and broadcast indications follow byte 0 and the later non-0xFF bytes, the hash index is zero after an idle cycle, and the miss flag clears after a frame start. Whether the decision is actually right needs the bench scenarios. These cover every single-byte mismatch position, every broadcast-breaking position, all 64 hash-table positions with the CRC input moving after capture, the control and promiscuous combinations, and a frame that leaves the data phase before the decision.

// File: rtl/daf_pkg.sv
package daf_pkg;

    // Running address classification of the frame being received
    typedef struct packed {
        logic uni;    // every address byte so far equals the station address
        logic bcast;  // every address byte so far is 0xFF
        logic mcast;  // group bit of the first byte was set
    } daf_class_t;

    // Decision stage registers
    typedef struct packed {
        logic pend;   // last address byte and hash index taken last cycle
        logic abort;  // reject pulse
        logic miss;   // address failed every check
    } daf_dec_t;

endpackage

// File: rtl/daf_classify.sv
module daf_classify
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int CNT_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [CNT_W-1:0]        byte_idx,
    input  logic [7:0]              rx_byte,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    clr,
    output daf_class_t              cls
);
    localparam int SEL_W = $clog2(ADDR_BYTES);
    localparam int SLOTS = 1 << SEL_W;

    logic [7:0]       sta_byte [SLOTS];
    logic             in_addr;
    logic             first;
    logic             match;
    logic             all_ones;
    logic [SEL_W-1:0] sel;
    daf_class_t       cls_d, cls_q;

    // Address bytes in transmission order, first byte from the top bits
    for (genvar g = 0; g < SLOTS; g++) begin : g_sta
        if (g < ADDR_BYTES) begin : g_real
            assign sta_byte[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
        end else begin : g_pad
            assign sta_byte[g] = 8'h00;
        end
    end

    assign in_addr  = byte_idx < CNT_W'(ADDR_BYTES);
    assign first    = byte_idx == '0;
    assign sel      = byte_idx[SEL_W-1:0];
    assign match    = rx_byte == sta_byte[sel];
    assign all_ones = &rx_byte;

    always_comb begin
        cls_d = cls_q;
        if (take && in_addr) begin
            if (first) begin
                cls_d.uni   = match;
                cls_d.bcast = all_ones;
                cls_d.mcast = rx_byte[0];
            end else begin
                cls_d.uni = cls_q.uni & match;
                if (!all_ones) begin
                    cls_d.bcast = 1'b0;
                end
            end
        end else if (clr) begin
            cls_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= '0;
        end else begin
            cls_q <= cls_d;
        end
    end

    assign cls = cls_q;

    // R6: the group indication only rises from bit 0 of the first byte
    a_r6_mcast_from_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cls_q.mcast) |-> $past(take && first && rx_byte[0]));

    // R4: a non-0xFF byte after the first removes broadcast status
    a_r4_bcast_broken: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_addr && !first && !all_ones) |=> !cls_q.bcast);

    // R4: broadcast status can only be set by a 0xFF first byte
    a_r4_bcast_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cls_q.bcast) |-> $past(take && first && all_ones));

endmodule

// File: rtl/daf_hash.sv
module daf_hash #(
    parameter int HASH_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_idle,
    input  logic                        capture,
    input  logic [HASH_W-1:0]           crc_hi,
    input  logic [(1<<(HASH_W-1))-1:0]  hash_lo,
    input  logic [(1<<(HASH_W-1))-1:0]  hash_hi,
    output logic                        hash_bit
);
    localparam int ENTRIES = 1 << HASH_W;

    logic [HASH_W-1:0]  idx_d, idx_q;
    logic [ENTRIES-1:0] table_bits;

    always_comb begin
        idx_d = idx_q;
        if (rx_idle) begin
            idx_d = '0;
        end else if (capture) begin
            idx_d = crc_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    // Upper half of the index space lives in the upper word
    assign table_bits = {hash_hi, hash_lo};
    assign hash_bit   = table_bits[idx_q];

    // R7: index is zero after any idle cycle
    a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idle |=> idx_q == '0);

    // R7: index only changes on capture or idle
    a_r7_index_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_idle && !capture) |=> $stable(idx_q));

endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       start,
    input  logic       rx_data_phase,
    input  logic       rx_idle,
    input  daf_class_t cls,
    input  logic       hash_bit,
    input  logic       bcast_block,
    input  logic       promisc,
    input  logic       pass_ctrl,
    input  logic       ctrl_addr_ok,
    output logic       abort,
    output logic       addr_miss
);
    daf_dec_t dec_d, dec_q;
    logic     addr_ok;
    logic     decide;

    assign addr_ok = cls.uni
                   | (cls.bcast & ~bcast_block)
                   | (cls.mcast & ~cls.bcast & hash_bit)
                   | (pass_ctrl & ctrl_addr_ok);

    assign decide = dec_q.pend & rx_data_phase & ~rx_idle;

    always_comb begin
        dec_d       = dec_q;
        dec_d.pend  = capture;
        dec_d.abort = 1'b0;
        if (start) begin
            dec_d.miss = 1'b0;
        end
        if (decide) begin
            dec_d.abort = ~addr_ok & ~promisc;
            dec_d.miss  = ~addr_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign abort     = dec_q.abort;
    assign addr_miss = dec_q.miss;

    // R10: abort is a single-cycle pulse
    a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.abort |=> !dec_q.abort);

    // R10: abort lands two clocks after the last address byte
    a_r10_abort_timing: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.abort |-> $past(capture, 2));

    // R10: no abort unless the receiver was in the data phase and busy
    a_r10_abort_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.abort |-> $past(rx_data_phase && !rx_idle));

    // R8: promiscuous mode never aborts
    a_r8_promisc_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        dec_q.abort |-> $past(!promisc));

    // R11: a frame start clears the miss flag
    a_r11_miss_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dec_q.pend) |=> !dec_q.miss);

    // R11: the miss flag holds between decisions and frame starts
    a_r11_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !dec_q.pend) |=> $stable(dec_q.miss));

endmodule

// File: rtl/daf_top.sv
module daf_top
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int CNT_W      = 8,
    parameter int HASH_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_idle,
    input  logic                       rx_data_phase,
    input  logic                       byte_valid,
    input  logic [CNT_W-1:0]           byte_idx,
    input  logic [7:0]                 rx_byte,
    input  logic                       frame_end,
    input  logic [HASH_W-1:0]          crc_hi,
    input  logic [8*ADDR_BYTES-1:0]    station_addr,
    input  logic                       bcast_block,
    input  logic                       promisc,
    input  logic [(1<<(HASH_W-1))-1:0] hash_lo,
    input  logic [(1<<(HASH_W-1))-1:0] hash_hi,
    input  logic                       pass_ctrl,
    input  logic                       ctrl_addr_ok,
    output logic                       abort,
    output logic                       addr_miss
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    logic       take;
    logic       capture;
    logic       start;
    logic       clr;
    logic       hash_bit;
    daf_class_t cls;

    assign take    = byte_valid & rx_data_phase;
    assign capture = take & (byte_idx == LAST_IDX);
    assign start   = take & (byte_idx == '0);
    assign clr     = frame_end | abort;

    daf_classify #(
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_W      (CNT_W)
    ) u_classify (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .byte_idx     (byte_idx),
        .rx_byte      (rx_byte),
        .station_addr (station_addr),
        .clr          (clr),
        .cls          (cls)
    );

    daf_hash #(
        .HASH_W (HASH_W)
    ) u_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_idle  (rx_idle),
        .capture  (capture),
        .crc_hi   (crc_hi),
        .hash_lo  (hash_lo),
        .hash_hi  (hash_hi),
        .hash_bit (hash_bit)
    );

    daf_decide u_decide (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .start         (start),
        .rx_data_phase (rx_data_phase),
        .rx_idle       (rx_idle),
        .cls           (cls),
        .hash_bit      (hash_bit),
        .bcast_block   (bcast_block),
        .promisc       (promisc),
        .pass_ctrl     (pass_ctrl),
        .ctrl_addr_ok  (ctrl_addr_ok),
        .abort         (abort),
        .addr_miss     (addr_miss)
    );

endmodule

// File: tb/daf_top_tb.sv
`timescale 1ns/1ps
module daf_top_tb;

    localparam logic [47:0] STA   = 48'h02_1A_2B_3C_4D_5E;
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [31:0] TLO   = 32'h9C3A_61E5;
    localparam logic [31:0] THI   = 32'h4B0F_D278;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_idle = 1'b1;
    logic        rx_data_phase = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_idx = '0;
    logic [7:0]  rx_byte = '0;
    logic        frame_end = 1'b0;
    logic [5:0]  crc_hi = '0;
    logic [47:0] station_addr = STA;
    logic        bcast_block = 1'b0;
    logic        promisc = 1'b0;
    logic [31:0] hash_lo = TLO;
    logic [31:0] hash_hi = THI;
    logic        pass_ctrl = 1'b0;
    logic        ctrl_addr_ok = 1'b0;
    logic        abort;
    logic        addr_miss;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    daf_top u_dut (
        .clk (clk), .rst_n (rst_n), .rx_idle (rx_idle),
        .rx_data_phase (rx_data_phase), .byte_valid (byte_valid),
        .byte_idx (byte_idx), .rx_byte (rx_byte), .frame_end (frame_end),
        .crc_hi (crc_hi), .station_addr (station_addr),
        .bcast_block (bcast_block), .promisc (promisc),
        .hash_lo (hash_lo), .hash_hi (hash_hi), .pass_ctrl (pass_ctrl),
        .ctrl_addr_ok (ctrl_addr_ok), .abort (abort), .addr_miss (addr_miss)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic tbl_bit(input logic [5:0] i);
        return (i < 6'd32) ? TLO[i[4:0]] : THI[i[4:0]];
    endfunction

    // Address acceptance computed from the requirements
    function automatic logic addr_ok(input logic [47:0] da, input logic [5:0] h);
        logic is_b;
        is_b = (da == BCAST);
        return (da == STA) || (is_b && !bcast_block) ||
               (da[40] && !is_b && tbl_bit(h)) || (pass_ctrl && ctrl_addr_ok);
    endfunction

    // Sends one frame's address and checks the decision
    task automatic frame(input string req, input logic [47:0] da,
                         input logic [5:0] h_at, input logic drop);
        logic ok;
        ok = addr_ok(da, h_at);
        @(negedge clk);
        rx_idle = 1'b0; rx_data_phase = 1'b1; crc_hi = ~h_at;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_idx = 8'(k);
            rx_byte = da[47-8*k -: 8];
            if (k == 5) crc_hi = h_at;
            @(negedge clk);
            byte_valid = 1'b0;
            if (k == 0) chk({req, " R11 miss cleared by start"}, addr_miss, 1'b0);
            if (k == 5) begin
                crc_hi = ~h_at;                  // R7: later CRC bits ignored
                if (drop) rx_data_phase = 1'b0;
            end
        end
        @(negedge clk);
        chk({req, " abort"}, abort, !ok && !promisc && !drop);
        chk({req, " addr_miss"}, addr_miss, drop ? 1'b0 : !ok);
        @(negedge clk);
        chk({req, " R10 abort one cycle"}, abort, 1'b0);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0; rx_data_phase = 1'b0; rx_idle = 1'b1;
        @(negedge clk);
        chk({req, " R11 miss held"}, addr_miss, drop ? 1'b0 : !ok);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R1 abort at reset", abort, 1'b0);
        chk("R1 miss at reset", addr_miss, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 abort after reset", abort, 1'b0);
        chk("R1 miss after reset", addr_miss, 1'b0);

        frame("R2 unicast match", STA, 6'd0, 1'b0);

        for (int p = 0; p < 6; p++) begin
            logic [47:0] da;
            da = STA ^ (48'h04 << (8 * (5 - p)));
            frame("R3 unicast mismatch", da, 6'd3, 1'b0);
        end

        frame("R4 broadcast kept", BCAST, 6'd1, 1'b0);
        for (int p = 0; p < 6; p++) begin
            logic [47:0] da;
            da = BCAST ^ (48'h10 << (8 * (5 - p)));
            frame("R4 broken broadcast lo", da, 6'd1, 1'b0);
            frame("R4 broken broadcast hi", da, 6'd0, 1'b0);
        end

        bcast_block = 1'b1;
        frame("R5 broadcast blocked", BCAST, 6'd0, 1'b0);
        promisc = 1'b1;
        frame("R5 R8 blocked broadcast promisc", BCAST, 6'd0, 1'b0);
        promisc = 1'b0;
        bcast_block = 1'b0;

        for (int i = 0; i < 64; i++) begin
            frame("R6 R7 hash sweep", {40'h01_00_5E_00_00, 8'(i)}, 6'(i), 1'b0);
        end

        promisc = 1'b1;
        frame("R8 promisc mismatch", STA ^ 48'h1, 6'd0, 1'b0);
        frame("R8 promisc match", STA, 6'd0, 1'b0);
        promisc = 1'b0;

        for (int c = 0; c < 4; c++) begin
            pass_ctrl = c[0]; ctrl_addr_ok = c[1];
            frame("R9 control path", 48'h06_00_00_00_00_01, 6'd0, 1'b0);
        end
        pass_ctrl = 1'b0; ctrl_addr_ok = 1'b0;

        frame("R10 left data phase", STA ^ 48'h100, 6'd0, 1'b1);
        frame("R11 miss then new frame", STA ^ 48'h2, 6'd0, 1'b0);
        frame("R11 follow-up match", STA, 6'd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule